// File: doc/BRIEF.md
# Tagged Local-History Branch Direction Predictor

This block predicts the direction of conditional branches from each branch's own recent behaviour. A tagged, 4-way set-associative table holds a short taken/not-taken history for every tracked branch. On a lookup the fetch address picks a set, and its upper bits are compared with the four stored tags. On a hit, the history of the matching way selects one of sixteen shared 2-bit saturating counters, and that counter's upper bit is the taken prediction.

Resolved branches come back on a separate update port. A branch that is already in the table steps its counter and shifts its history. A branch that misses and is resolved taken gets a new entry, placed in a victim way chosen by a per-set tree pseudo-LRU. A branch that misses and is resolved not taken leaves the table unchanged. Lookup results are combinational from the table state, so a lookup and an update in the same cycle see the contents as they were before that update.

Top module: `lhp_predictor`

## Requirements
- R1: After reset no address hits: `lk_hit` and `lk_taken` are 0 until a taken update has allocated an entry.
- R2: With `lk_valid` high, `lk_hit` is 1 exactly when a valid way of set `lk_addr[6:0]` holds tag `lk_addr[15:7]`. On a miss, or with `lk_valid` low, `lk_hit` and `lk_taken` are both 0.
- R3: On a hit, `lk_taken` is bit 1 of the counter that the hit way's 4-bit history indexes, out of 16 counters shared by all entries. All counters reset to 00. Codes 11 and 10 predict taken, 01 and 00 predict not taken.
- R4: An update that hits moves the counter indexed by the history held before that update one step toward the outcome, saturating at 11 and 00.
- R5: An update that hits shifts that way's history left by one and places the outcome (1 = taken) in bit 0.
- R6: A taken update that misses creates an entry with history 0001 and sets counter 0001 to 11 (strongly taken).
- R7: A not-taken update that misses changes no entry, no counter and no replacement state.
- R8: On allocation the victim is the lowest-numbered invalid way of the set. If all four ways are valid, it is the way named by the set's 3-bit tree state (reset 000): bit 0 picks the half (0 = ways 0/1, 1 = ways 2/3), bit 1 picks within ways 0/1, and bit 2 picks within ways 2/3.
- R9: A lookup hit, an update hit and an allocation each mark their way most recently used: the tree bits on the way's path are set to point away from it. When a lookup hit and an update touch the same set in one cycle, only the update's touch takes effect.
- R10: A lookup in the same cycle as an update to the same branch or set returns the contents held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 16 | Fetch address to predict |
| lk_hit | output | 1 | Lookup found a tracked branch |
| lk_taken | output | 1 | Predicted taken |
| up_valid | input | 1 | Resolved branch update |
| up_addr | input | 16 | Address of resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A corrupted history bit shows up at once: it redirects the next lookup of that branch to the wrong shared counter, so `lk_taken` can flip on the very next cycle. A wrong victim choice or replacement-state update stays hidden until a fifth tag lands in a full set, and then it appears as an unexpected hit or miss on a branch that should have survived. Counter saturation faults take several same-direction updates of one history pattern before they flip a prediction. Same-set collisions therefore have to be driven deliberately, together with long taken and not-taken runs.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  localparam int unsigned NWAYS = 4;
  localparam int unsigned WAY_W = 2;
  localparam logic [1:0] CTR_ST = 2'b11;
  localparam logic [1:0] CTR_SN = 2'b00;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic t);
    logic [1:0] r;
    r = c;
    if (t && c != 2'b11) r = c + 2'd1;
    if (!t && c != 2'b00) r = c - 2'd1;
    return r;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] s, input logic [WAY_W-1:0] w);
    logic [2:0] r;
    r = s;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] plru_victim(input logic [2:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction
endpackage

// File: rtl/lhp_tag_match.sv
module lhp_tag_match #(
  parameter int unsigned TAG_W = 9,
  parameter int unsigned NWAYS = 4,
  localparam int unsigned WAY_W = $clog2(NWAYS)
) (
  input  logic [NWAYS-1:0]            vld,
  input  logic [NWAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            way
);
  logic [NWAYS-1:0] match;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w] == tag);
  end

  always_comb begin
    way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (match[w]) way = WAY_W'(w);
    end
  end

  assign hit = |match;

  // R2: a tag is held by at most one way of a set
  always_comb begin
    if (!$isunknown(match)) begin
      assert_one_way_R2: assert ($onehot0(match));
    end
  end
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table #(
  parameter int unsigned HIST_W = 4,
  localparam int unsigned NCTR = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic [1:0]        rd_ctr,
  input  logic              step_en,
  input  logic              alloc_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              taken
);
  import lhp_pkg::*;

  logic [1:0] ctr_q [NCTR];
  logic [1:0] ctr_d [NCTR];

  always_comb begin
    ctr_d = ctr_q;
    if (step_en)       ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], taken);
    else if (alloc_en) ctr_d[wr_idx] = CTR_ST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTR; i++) ctr_q[i] <= CTR_SN;
    end else if (step_en || alloc_en) begin
      ctr_q <= ctr_d;
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);
  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !taken && ctr_q[wr_idx] == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00);
  assert_alloc_strong_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !step_en) |=> ctr_q[$past(wr_idx)] == 2'b11);
endmodule

// File: rtl/lhp_plru.sv
module lhp_plru #(
  parameter int unsigned SET_W = 7,
  localparam int unsigned NSETS = 1 << SET_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_en,
  input  logic [SET_W-1:0]         lk_set,
  input  logic [lhp_pkg::WAY_W-1:0] lk_way,
  input  logic                     up_en,
  input  logic [SET_W-1:0]         up_set,
  input  logic [lhp_pkg::WAY_W-1:0] up_way,
  output logic [lhp_pkg::WAY_W-1:0] victim
);
  import lhp_pkg::*;

  logic [2:0] st_q [NSETS];
  logic [2:0] st_d [NSETS];

  always_comb begin
    st_d = st_q;
    if (lk_en) st_d[lk_set] = plru_touch(st_q[lk_set], lk_way);
    if (up_en) st_d[up_set] = plru_touch(st_q[up_set], up_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) st_q[i] <= 3'b000;
    end else if (lk_en || up_en) begin
      st_q <= st_d;
    end
  end

  assign victim = plru_victim(st_q[up_set]);

  // R9: a just-touched way is never the next victim of its set
  assert_mru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> plru_victim(st_q[$past(up_set)]) != $past(up_way));
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SET_W  = 7,
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  import lhp_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - SET_W;
  localparam int unsigned NSETS = 1 << SET_W;
  localparam logic [HIST_W-1:0] HIST_NEW = HIST_W'(1);

  logic [NWAYS-1:0]                   vld_q [NSETS];
  logic [NWAYS-1:0]                   vld_d [NSETS];
  logic [NWAYS-1:0][TAG_W-1:0]        tag_q [NSETS];
  logic [NWAYS-1:0][HIST_W-1:0]       hist_q [NSETS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_m_hit, up_m_hit;
  logic [WAY_W-1:0] lk_way, up_way, tree_vic, victim, wr_way;
  logic             up_hit, up_alloc, wr_en;
  logic [HIST_W-1:0] lk_hist, up_hist, hist_new;
  logic [1:0]       lk_ctr;

  assign lk_set = lk_addr[SET_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:SET_W];
  assign up_set = up_addr[SET_W-1:0];
  assign up_tag = up_addr[ADDR_W-1:SET_W];

  lhp_tag_match #(.TAG_W(TAG_W), .NWAYS(NWAYS)) i_lk_match (
    .vld(vld_q[lk_set]), .tags(tag_q[lk_set]), .tag(lk_tag),
    .hit(lk_m_hit), .way(lk_way));

  lhp_tag_match #(.TAG_W(TAG_W), .NWAYS(NWAYS)) i_up_match (
    .vld(vld_q[up_set]), .tags(tag_q[up_set]), .tag(up_tag),
    .hit(up_m_hit), .way(up_way));

  assign up_hit   = up_valid && up_m_hit;
  assign up_alloc = up_valid && !up_m_hit && up_taken;
  assign wr_en    = up_hit || up_alloc;

  always_comb begin
    victim = tree_vic;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!vld_q[up_set][w]) victim = WAY_W'(w);
    end
  end

  assign wr_way   = up_hit ? up_way : victim;
  assign lk_hist  = hist_q[lk_set][lk_way];
  assign up_hist  = hist_q[up_set][up_way];
  assign hist_new = up_hit ? {up_hist[HIST_W-2:0], up_taken} : HIST_NEW;

  lhp_ctr_table #(.HIST_W(HIST_W)) i_ctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_hist), .rd_ctr(lk_ctr),
    .step_en(up_hit), .alloc_en(up_alloc),
    .wr_idx(up_hit ? up_hist : HIST_NEW), .taken(up_taken));

  lhp_plru #(.SET_W(SET_W)) i_plru (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_valid && lk_m_hit), .lk_set(lk_set), .lk_way(lk_way),
    .up_en(wr_en), .up_set(up_set), .up_way(wr_way),
    .victim(tree_vic));

  always_comb begin
    vld_d = vld_q;
    if (up_alloc) vld_d[up_set][victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) vld_q[i] <= '0;
    end else if (up_alloc) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_set][wr_way]  <= up_tag;
      hist_q[up_set][wr_way] <= hist_new;
    end
  end

  assign lk_hit   = lk_valid && lk_m_hit;
  assign lk_taken = lk_hit && lk_ctr[1];

  assert_alloc_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_alloc |=> vld_q[$past(up_set)][$past(victim)]);
  assert_nt_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && !up_m_hit) |=> vld_q[$past(up_set)] == $past(vld_q[up_set]));
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_hit |=> hist_q[$past(up_set)][$past(up_way)][0] == $past(up_taken));
endmodule

// File: tb/test_lhp_predictor.sv
module test_lhp_predictor;
  logic clk, rst_n;
  logic lk_valid, lk_hit, lk_taken, up_valid, up_taken;
  logic [15:0] lk_addr, up_addr;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic       m_vld  [128][4];
  logic [8:0] m_tag  [128][4];
  logic [3:0] m_hist [128][4];
  logic [2:0] m_plru [128];
  logic [1:0] m_ctr  [16];

  lhp_predictor i_lhp_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [2:0] b_touch(input logic [2:0] s, input int w);
    logic [2:0] r = s;
    r[0] = (w < 2);
    if (w == 0) r[1] = 1'b1;
    if (w == 1) r[1] = 1'b0;
    if (w == 2) r[2] = 1'b1;
    if (w == 3) r[2] = 1'b0;
    return r;
  endfunction

  function automatic int b_tree(input logic [2:0] s);
    if (s[0] == 1'b0) return s[1] ? 1 : 0;
    return s[2] ? 3 : 2;
  endfunction

  function automatic int b_find(input logic [15:0] a);
    for (int w = 0; w < 4; w++)
      if (m_vld[a[6:0]][w] && m_tag[a[6:0]][w] == a[15:7]) return w;
    return -1;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic lv, input logic [15:0] la,
                     input logic uv, input logic [15:0] ua, input logic ut);
    int lw, uw, vw, ls, us;
    logic eh, et;
    logic [2:0] pre_l, pre_u;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut;
    #1;
    lw = b_find(la); uw = b_find(ua);
    ls = int'(la[6:0]); us = int'(ua[6:0]);
    eh = lv && (lw >= 0);
    et = eh && m_ctr[m_hist[ls][lw]][1];
    check(lk_hit, eh, "lk_hit");
    check(lk_taken, et, "lk_taken");
    pre_l = m_plru[ls]; pre_u = m_plru[us];
    if (eh) m_plru[ls] = b_touch(pre_l, lw);
    if (uv && uw >= 0) begin
      m_ctr[m_hist[us][uw]] = ut ? ((m_ctr[m_hist[us][uw]] == 2'b11) ? 2'b11 : m_ctr[m_hist[us][uw]] + 2'd1)
                                 : ((m_ctr[m_hist[us][uw]] == 2'b00) ? 2'b00 : m_ctr[m_hist[us][uw]] - 2'd1);
      m_hist[us][uw] = {m_hist[us][uw][2:0], ut};
      m_plru[us] = b_touch(pre_u, uw);
    end else if (uv && ut) begin
      vw = -1;
      for (int w = 3; w >= 0; w--) if (!m_vld[us][w]) vw = w;
      if (vw < 0) vw = b_tree(pre_u);
      m_vld[us][vw] = 1'b1; m_tag[us][vw] = ua[15:7]; m_hist[us][vw] = 4'b0001;
      m_ctr[1] = 2'b11;
      m_plru[us] = b_touch(pre_u, vw);
    end
  endtask

  function automatic logic [15:0] mk(input int tag, input int set);
    return {9'(tag), 7'(set)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    int sets [3] = '{3, 5, 77};
    void'($urandom(32'd4242));
    for (int s = 0; s < 128; s++) begin
      m_plru[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_hist[s][w] = '0; end
    end
    for (int i = 0; i < 16; i++) m_ctr[i] = 2'b00;
    rst_n = 1'b0; lk_valid = 0; lk_addr = 0; up_valid = 0; up_addr = 0; up_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    cyc(1, mk(0, 0), 0, 0, 0);
    cyc(1, mk(5, 3), 0, 0, 0);
    cyc(1, mk(511, 127), 0, 0, 0);

    cur_req = "R7";
    a = mk(2, 10);
    cyc(0, 0, 1, a, 0);
    cyc(1, a, 0, 0, 0);

    cur_req = "R6";
    cyc(1, a, 1, a, 1);
    cyc(1, a, 0, 0, 0);

    cur_req = "R10";
    for (int k = 0; k < 7; k++) cyc(1, a, 1, a, 1);
    cur_req = "R4";
    for (int k = 0; k < 8; k++) cyc(1, a, 1, a, 0);
    cur_req = "R5";
    for (int k = 0; k < 6; k++) cyc(1, a, 1, a, k[0]);

    cur_req = "R2";
    cyc(1, mk(3, 10), 0, 0, 0);
    cyc(0, a, 0, 0, 0);

    cur_req = "R8";
    for (int t = 0; t < 6; t++) cyc(1, mk(t, 20), 1, mk(t, 20), 1);
    for (int t = 0; t < 6; t++) cyc(1, mk(t, 20), 0, 0, 0);

    cur_req = "R9";
    cyc(1, mk(4, 20), 1, mk(5, 20), 1);
    cyc(1, mk(9, 20), 1, mk(9, 20), 1);
    for (int t = 0; t < 10; t++) cyc(1, mk(t, 20), 0, 0, 0);

    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      a = mk(int'($urandom % 7), sets[$urandom % 3]);
      b = ($urandom % 4 == 0) ? a : mk(int'($urandom % 7), sets[$urandom % 3]);
      cyc(($urandom % 8) != 0, a, ($urandom % 4) != 0, b, ($urandom % 3) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule